// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Write Latch

This block is the parallel front end of a converter's digital interface. A host drives a 14-bit two's complement word on a data bus and controls three active-low asynchronous strobes: a chip select, a write strobe and a load strobe. Two registers sit behind those pins. The staging register is loaded from the bus by a write. The output register holds the word that the converter is presenting. The block is clocked by a fast system clock. It samples every strobe through a synchronizer and reproduces level-sensitive latch behaviour with edge-triggered logic.

The two registers are never open at the same time. While a write is in progress, nothing moves into the output register. A falling load strobe copies the staged word to the output. If the load strobe is held low permanently, the output register tracks the staging register, so every completed write updates the output without any further action. The output register is exposed together with a one-clock pulse that marks each cycle in which it is loaded.

Top module: `dac_dbuf_wlatch`

## Requirements
- R1: While reset is asserted, and directly after it is released, the output register reads 0 (midscale) and the update pulse is low.
- R2: While chip select and write strobe are both low, the staging register follows the bus. The word it keeps is the bus value present when either strobe returns high.
- R3: A falling edge of the load strobe, outside a write, copies the staging register into the output register and raises the update pulse for exactly that cycle.
- R4: While the load strobe is high, writes change only the staging register. The output register holds and no update pulse appears.
- R5: While chip select and write strobe are both low, no transfer into the output register takes place, even if the load strobe falls or is low.
- R6: With the load strobe low, the output register takes the new staged word in the cycle in which the end of the write is detected, and the update pulse fires once.
- R7: No update happens until the synchronized load strobe has been seen high at least once after reset. A load strobe held low from reset onward leaves the output at 0.
- R8: Each strobe passes through a two-flop synchronizer. An output change caused by a strobe edge appears after the third rising clock edge following that edge. The bus value used when a write ends is the one sampled at the second rising edge after the strobe rises.
- R9: A write strobe pulse while chip select is high does not alter the staging register. A later load transfers the earlier staged word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 14 | Parallel data word, two's complement |
| sel_n_i | input | 1 | Active-low chip select (asynchronous) |
| wr_n_i | input | 1 | Active-low write strobe (asynchronous) |
| ld_n_i | input | 1 | Active-low load strobe (asynchronous) |
| dac_o | output | 14 | Output register contents |
| upd_o | output | 1 | One-clock pulse in each cycle the output register is loaded |

## Verification
A strobe edge driven between clock edges reaches the synchronized domain after two rising edges. Its effect on `dac_o` and `upd_o` appears after the third edge. The bus word latched at the end of a write is the one present at the second edge. The bench drives all inputs on falling edges and samples the outputs on falling edges. A behavioural model keeps a short history of the sampled inputs and applies the same three-edge delay, and it is compared against the design on every cycle. The targeted checks wait well past that delay, except for one test that probes the cycles just before, at and after the expected update edge.

// File: rtl/dac_dbuf_wlatch.sv
module dac_dbuf_wlatch #(
  parameter int DW          = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_i,
  input  logic          sel_n_i,
  input  logic          wr_n_i,
  input  logic          ld_n_i,
  output logic [DW-1:0] dac_o,
  output logic          upd_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]  sel_sr, wr_sr, ld_sr;
  logic [DW-1:0] bus_q, stage_q, stage_nxt;
  logic          act_q, ld_q, armed_q;
  logic          sel_s, wr_s, ld_s, act, act_end, ld_fall, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr <= '1;
      wr_sr  <= '1;
      ld_sr  <= '0;
    end else begin
      sel_sr <= {sel_sr[TOP-1:0], sel_n_i};
      wr_sr  <= {wr_sr[TOP-1:0], wr_n_i};
      ld_sr  <= {ld_sr[TOP-1:0], ld_n_i};
    end
  end

  assign sel_s   = sel_sr[TOP];
  assign wr_s    = wr_sr[TOP];
  assign ld_s    = ld_sr[TOP];
  assign act     = ~sel_s & ~wr_s;
  assign act_end = act_q & ~act;
  assign ld_fall = ld_q & ~ld_s;

  assign stage_nxt = (act | act_end) ? bus_q : stage_q;
  assign load      = armed_q & ~act & ~ld_s & (ld_fall | act_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      stage_q <= '0;
      act_q   <= 1'b0;
      ld_q    <= 1'b0;
      armed_q <= 1'b0;
      dac_o   <= '0;
      upd_o   <= 1'b0;
    end else begin
      bus_q   <= bus_i;
      stage_q <= stage_nxt;
      act_q   <= act;
      ld_q    <= ld_s;
      armed_q <= armed_q | ld_s;
      upd_o   <= load;
      if (load) dac_o <= stage_nxt;
    end
  end

endmodule

// File: rtl/dac_dbuf_wlatch_chk.sv
module dac_dbuf_wlatch_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n_i,
  input logic          wr_n_i,
  input logic          ld_n_i,
  input logic [DW-1:0] dac_o,
  input logic          upd_o
);

  logic ld_hi_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_hi_seen <= 1'b0;
    else if (ld_n_i) ld_hi_seen <= 1'b1;
  end

  AST_CHANGE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_o != $past(dac_o)) |-> upd_o); // R3

  AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_n_i, 3) |-> !upd_o); // R4

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sel_n_i, 3) && !$past(wr_n_i, 3)) |-> !upd_o); // R5

  AST_ARMED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> ld_hi_seen); // R7

endmodule

bind dac_dbuf_wlatch dac_dbuf_wlatch_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .wr_n_i(wr_n_i),
  .ld_n_i(ld_n_i), .dac_o(dac_o), .upd_o(upd_o)
);

// File: tb/dac_dbuf_wlatch_bench.sv
`timescale 1ns/1ps
module dac_dbuf_wlatch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus = '0;
  logic        sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b0;
  logic [13:0] dac_o;
  logic        upd_o;
  int          n_chk = 0, n_fail = 0, p_cnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_wlatch u_dac_dbuf_wlatch (
    .clk(clk), .rst_n(rst_n), .bus_i(bus), .sel_n_i(sel_n), .wr_n_i(wr_n),
    .ld_n_i(ld_n), .dac_o(dac_o), .upd_o(upd_o)
  );

  // behavioural reference: input history, three-edge response
  logic        ha[4], hl[4];
  logic [13:0] hb[2];
  logic [13:0] m_in, m_dac, m_nxt;
  logic        m_upd, m_arm, m_act, m_end, m_fall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ha[i] = 1'b0; hl[i] = 1'b0; end
      hb[0] = '0; hb[1] = '0;
      m_in = '0; m_dac = '0; m_upd = 1'b0; m_arm = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin ha[i] = ha[i-1]; hl[i] = hl[i-1]; end
      ha[0] = ~sel_n & ~wr_n;
      hl[0] = ld_n;
      hb[1] = hb[0];
      hb[0] = bus;
      m_arm  = m_arm | hl[3];
      m_act  = ha[2];
      m_end  = ha[3] & ~ha[2];
      m_fall = hl[3] & ~hl[2];
      m_nxt  = (m_act | m_end) ? hb[1] : m_in;
      m_upd  = m_arm & ~m_act & ~hl[2] & (m_fall | m_end);
      if (m_upd) m_dac = m_nxt;
      m_in = m_nxt;
    end
  end

  always @(posedge clk) if (rst_n && upd_o) p_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(dac_o == m_dac, "R8 model dac", dac_o, m_dac);
      chk(upd_o == m_upd, "R8 model upd", upd_o, m_upd);
    end
  end

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_word(input logic [13:0] v);
    @(negedge clk);
    bus = v; sel_n = 1'b0; wr_n = 1'b0;
    ncyc(3); wr_n = 1'b1;
    ncyc(4); sel_n = 1'b1;
    ncyc(4);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    ncyc(3);
    chk(dac_o == 14'h0, "R1 reset dac", dac_o, 0);
    chk(upd_o == 1'b0, "R1 reset upd", upd_o, 0);
    rst_n = 1'b1;
    ncyc(3);
    chk(dac_o == 14'h0, "R1 after release", dac_o, 0);

    wr_word(14'h1234); ncyc(4);
    chk(dac_o == 14'h0, "R7 unarmed dac", dac_o, 0);
    chk(p_cnt == 0, "R7 unarmed pulses", p_cnt, 0);

    ld_n = 1'b1; ncyc(4);
    wr_word(14'h0ABC);
    chk(dac_o == 14'h0, "R4 hold dac", dac_o, 0);
    chk(p_cnt == 0, "R4 hold pulses", p_cnt, 0);

    ld_n = 1'b0; ncyc(5);
    chk(dac_o == 14'h0ABC, "R3 ld fall dac", dac_o, 14'h0ABC);
    chk(p_cnt == 1, "R3 ld fall pulses", p_cnt, 1);

    ld_n = 1'b1; ncyc(4);
    bus = 14'h1111; sel_n = 1'b0; wr_n = 1'b0; ncyc(3);
    bus = 14'h2222; ncyc(3);
    bus = 14'h3333; ncyc(3);
    wr_n = 1'b1; ncyc(4); sel_n = 1'b1; ncyc(3);
    chk(dac_o == 14'h0ABC, "R4 transparent hold", dac_o, 14'h0ABC);
    ld_n = 1'b0; ncyc(5);
    chk(dac_o == 14'h3333, "R2 last bus value", dac_o, 14'h3333);
    chk(p_cnt == 2, "R2 pulses", p_cnt, 2);

    wr_word(14'h0555);
    chk(dac_o == 14'h0555, "R6 follow dac", dac_o, 14'h0555);
    chk(p_cnt == 3, "R6 follow pulses", p_cnt, 3);

    ld_n = 1'b1; ncyc(4);
    bus = 14'h1F0F; sel_n = 1'b0; wr_n = 1'b0; ncyc(4);
    ld_n = 1'b0; ncyc(6);
    chk(dac_o == 14'h0555, "R5 blocked dac", dac_o, 14'h0555);
    chk(p_cnt == 3, "R5 blocked pulses", p_cnt, 3);
    wr_n = 1'b1; ncyc(4); sel_n = 1'b1; ncyc(3);
    chk(dac_o == 14'h1F0F, "R6 after block dac", dac_o, 14'h1F0F);
    chk(p_cnt == 4, "R6 after block pulses", p_cnt, 4);

    bus = 14'h3FFF; wr_n = 1'b0; ncyc(4); wr_n = 1'b1; ncyc(4);
    chk(dac_o == 14'h1F0F, "R9 no select dac", dac_o, 14'h1F0F);
    chk(p_cnt == 4, "R9 no select pulses", p_cnt, 4);
    ld_n = 1'b1; ncyc(4); ld_n = 1'b0; ncyc(5);
    chk(dac_o == 14'h1F0F, "R9 staged kept", dac_o, 14'h1F0F);
    chk(p_cnt == 5, "R9 reload pulses", p_cnt, 5);

    ld_n = 1'b1; ncyc(4);
    wr_word(14'h2AAA);
    ld_n = 1'b0;
    ncyc(1);
    chk(dac_o == 14'h1F0F && !upd_o, "R8 edge1", dac_o, 14'h1F0F);
    ncyc(1);
    chk(dac_o == 14'h1F0F && !upd_o, "R8 edge2", dac_o, 14'h1F0F);
    ncyc(1);
    chk(dac_o == 14'h2AAA, "R8 edge3 dac", dac_o, 14'h2AAA);
    chk(upd_o == 1'b1, "R8 edge3 upd", upd_o, 1);
    ncyc(1);
    chk(upd_o == 1'b0, "R8 one cycle pulse", upd_o, 0);
    ncyc(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

endmodule